// File: doc/BRIEF.md
# Parallel Device PIO Cycle Sequencer

This block performs one programmed-I/O transfer at a time to a 16-bit parallel storage device. A host accepts a bus access that has already been decoded to one of 16 device registers. It then hands the sequencer a register index, a direction and, for writes, a data word. The sequencer drives the device address, chip-select, read or write strobe and the data-enable for the bidirectional data pins. The cycle passes through four phases, each with a clock count of its own: address setup, active strobe, data hold and end-of-cycle recovery. A read-modify-write from the host is issued as a read transfer followed by a write transfer to the same index.

The request side is a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on the clock where `req_valid` and `req_ready` are both high. While the block is busy it applies back-pressure: a request that is withdrawn before `req_ready` returns is never performed. The response side has no back-pressure. `rsp_valid` is a single-clock pulse, and the consumer must take `rsp_rdata` in that clock. The pulse comes at the end of the hold phase, so the host acknowledge does not wait for recovery.

When the latched enable is set, the device ready line can stretch the strobe phase. The ready line passes through a two-flop synchronizer. The strobe then stays active until both of these hold: its count has expired, and the synchronized ready is high.

Top module: `pio_seq`

## Requirements
- R1: While reset is held and after reset is released, the block is idle. In this state `dev_cs_n`, `dev_rd_n` and `dev_wr_n` are 1, `dev_data_oe`, `busy` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: The clock after a request is accepted starts the setup phase. Setup lasts exactly S clocks, where S may be 0. During setup `dev_cs_n` is 0 and both strobes are 1. `dev_addr` shows the accepted index from the start of setup to the end of hold.
- R3: The strobe phase follows setup and lasts T+1 clocks. Only `dev_rd_n` is low on a read (`req_write`=0), and only `dev_wr_n` is low on a write (`req_write`=1).
- R4: The hold phase follows the strobe. It lasts H clocks, where H may be 0, with `dev_cs_n` 0 and both strobes 1. On a write, `dev_data_oe` is 1 and `dev_data_out` equals the accepted write word unchanged, from setup through hold. On a read, `dev_data_oe` stays 0.
- R5: On a read, `rsp_rdata` holds the `dev_data_in` value present in the last strobe clock. On a write, it holds 0.
- R6: `rsp_valid` is high for exactly one clock. That clock is the first one after the hold phase, which is S+T+1+H clocks after the first setup clock. `dev_cs_n` is already 1 in that clock.
- R7: Recovery lasts E clocks with `dev_cs_n` 1 and `busy` 1. `busy` is high for S+(strobe length)+H+E clocks in total. E may be 0.
- R8: `req_ready` is 0 for the whole time `busy` is 1. A request presented then and withdrawn before idle starts no transfer.
- R9: The 32-bit `timing` word is captured on acceptance. Its fields are S in [7:0], T in [15:8], H in [23:16] and E in [31:24], each a clock count. The values 0x18021C04 and 0x02000600 give correct cycles.
- R10: `rdy_ext_en` is captured on acceptance. If it is 1, the strobe cannot end while `dev_ready`, delayed by two clocks, is low. If `dev_ready` rises during clock r of the transfer (counted from the first setup clock as 0), the strobe lasts max(T+1, r+3-S) clocks.
- R11: If the captured `rdy_ext_en` is 0, `dev_ready` is ignored: a ready line held low leaves the strobe at T+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_index | input | 4 | Device register index |
| req_wdata | input | 16 | Write data word |
| timing | input | 32 | Packed phase counts (E, H, T, S from high to low byte) |
| rdy_ext_en | input | 1 | Allow device ready to stretch the strobe |
| dev_ready | input | 1 | Asynchronous device ready line |
| dev_addr | output | 4 | Device register address |
| dev_cs_n | output | 1 | Device chip-select, active low |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_data_oe | output | 1 | Enable for the device data pin drivers |
| dev_data_out | output | 16 | Data driven to the device |
| dev_data_in | input | 16 | Data returned by the device |
| rsp_valid | output | 1 | One-clock transfer completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| busy | output | 1 | Transfer or recovery in progress |

## Verification
The assertions assume that `req_valid` rises only from idle or is dropped again while busy. They also assume that `dev_data_in` and `dev_ready` may change on any clock, so no property ties either one to a particular strobe clock. The stimulus moves every input half a clock away from the active edge. It lowers `dev_ready` at least four clocks before each request so that the synchronizer is settled, and it changes `timing` only between transfers. The near-exhaustive sweep covers every combination of phase counts from 0 to 2 in both directions, plus the two extreme packed words. Every expected phase length, pulse position and read value in it is derived arithmetically from the counts.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  parameter int PH_CNT_W = 8;
  localparam int TIM_W = 4 * PH_CNT_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RECOV
  } pio_phase_e;

  // field order is fixed by the packing of the timing input
  typedef struct packed {
    logic [PH_CNT_W-1:0] recov;
    logic [PH_CNT_W-1:0] hold;
    logic [PH_CNT_W-1:0] strobe;
    logic [PH_CNT_W-1:0] setup;
  } pio_timing_t;
endpackage

// File: rtl/pio_ready_sync.sv
module pio_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/pio_phase_ctr.sv
module pio_phase_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_seq_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TIM_W-1:0]  timing,
  input  logic              rdy_ext_en,
  input  logic              dev_ready,
  output logic [IDX_W-1:0]  dev_addr,
  output logic              dev_cs_n,
  output logic              dev_rd_n,
  output logic              dev_wr_n,
  output logic              dev_data_oe,
  output logic [DATA_W-1:0] dev_data_out,
  input  logic [DATA_W-1:0] dev_data_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy
);
  pio_phase_e          phase_q, nxt;
  pio_timing_t         tim_in, tim_q;
  logic                ext_q, wr_q, done_q;
  logic [IDX_W-1:0]    idx_q;
  logic [DATA_W-1:0]   wd_q, rdata_q;
  logic                rdy_s, cnt_zero;
  logic                ld, dec, fin, cap, accept, active;
  logic [PH_CNT_W-1:0] ld_val;

  assign tim_in = timing;
  assign accept = req_valid && (phase_q == PH_IDLE);

  pio_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(dev_ready), .q(rdy_s)
  );

  pio_phase_ctr #(.W(PH_CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
    .dec(dec), .zero(cnt_zero)
  );

  always_comb begin
    nxt    = phase_q;
    ld     = 1'b0;
    ld_val = '0;
    dec    = 1'b0;
    fin    = 1'b0;
    cap    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          ld = 1'b1;
          if (tim_in.setup != '0) begin
            nxt    = PH_SETUP;
            ld_val = tim_in.setup - 1'b1;
          end else begin
            nxt    = PH_STROBE;
            ld_val = tim_in.strobe;
          end
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          nxt    = PH_STROBE;
          ld     = 1'b1;
          ld_val = tim_q.strobe;
        end else dec = 1'b1;
      end
      PH_STROBE: begin
        if (cnt_zero && (!ext_q || rdy_s)) begin
          cap = 1'b1;
          if (tim_q.hold != '0) begin
            nxt    = PH_HOLD;
            ld     = 1'b1;
            ld_val = tim_q.hold - 1'b1;
          end else fin = 1'b1;
        end else dec = 1'b1;
      end
      PH_HOLD: begin
        if (cnt_zero) fin = 1'b1;
        else          dec = 1'b1;
      end
      PH_RECOV: begin
        if (cnt_zero) nxt = PH_IDLE;
        else          dec = 1'b1;
      end
      default: nxt = PH_IDLE;
    endcase
    if (fin) begin
      if (tim_q.recov != '0) begin
        nxt    = PH_RECOV;
        ld     = 1'b1;
        ld_val = tim_q.recov - 1'b1;
      end else nxt = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tim_q   <= '0;
      ext_q   <= 1'b0;
      wr_q    <= 1'b0;
      idx_q   <= '0;
      wd_q    <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= nxt;
      done_q  <= fin;
      if (accept) begin
        tim_q <= tim_in;
        ext_q <= rdy_ext_en;
        wr_q  <= req_write;
        idx_q <= req_index;
        wd_q  <= req_wdata;
      end
      if (cap) rdata_q <= wr_q ? '0 : dev_data_in;
    end
  end

  assign active       = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) || (phase_q == PH_HOLD);
  assign busy         = (phase_q != PH_IDLE);
  assign req_ready    = (phase_q == PH_IDLE);
  assign dev_cs_n     = !active;
  assign dev_rd_n     = !((phase_q == PH_STROBE) && !wr_q);
  assign dev_wr_n     = !((phase_q == PH_STROBE) && wr_q);
  assign dev_data_oe  = active && wr_q;
  assign dev_data_out = wd_q;
  assign dev_addr     = idx_q;
  assign rsp_valid    = done_q;
  assign rsp_rdata    = rdata_q;
endmodule

// File: rtl/pio_seq_chk.sv
module pio_seq_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             cs_n,
  input logic             rd_n,
  input logic             wr_n,
  input logic             oe,
  input logic [IDX_W-1:0] addr,
  input logic             rsp_valid
);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !cs_n);

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(addr));

  p_no_drive_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> rd_n);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_done_after_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cs_n);

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
endmodule

bind pio_seq pio_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .cs_n(dev_cs_n), .rd_n(dev_rd_n), .wr_n(dev_wr_n),
  .oe(dev_data_oe), .addr(dev_addr), .rsp_valid(rsp_valid)
);

// File: tb/pio_seq_test.sv
`timescale 1ns/1ps
module pio_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rdy_ext_en = 1'b0, dev_ready = 1'b0;
  logic [3:0]  req_index = '0;
  logic [15:0] req_wdata = '0;
  logic [31:0] timing = '0;
  logic        req_ready, dev_cs_n, dev_rd_n, dev_wr_n, dev_data_oe, rsp_valid, busy;
  logic [3:0]  dev_addr;
  logic [15:0] dev_data_out, rsp_rdata, dev_data_in;
  logic [7:0]  pat = 8'h5A;
  logic [7:0]  tick = '0;
  int          errors = 0, checks = 0, total_cyc = 0;

  always #2 clk = ~clk;

  // device model: read value changes every clock
  always @(posedge clk) tick <= tick + 8'd1;
  assign dev_data_in = {pat, tick};

  pio_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_index(req_index), .req_wdata(req_wdata),
    .timing(timing), .rdy_ext_en(rdy_ext_en), .dev_ready(dev_ready),
    .dev_addr(dev_addr), .dev_cs_n(dev_cs_n), .dev_rd_n(dev_rd_n),
    .dev_wr_n(dev_wr_n), .dev_data_oe(dev_data_oe), .dev_data_out(dev_data_out),
    .dev_data_in(dev_data_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .busy(busy)
  );

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      $display("FAIL watchdog: got %0d cycles expected < 150000", total_cyc);
      $display("  Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  // one transfer; rdy_at: -1 ready low throughout, -2 ready high, >=0 rises in that clock
  task automatic run_cycle(input bit wr, input logic [3:0] idx, input logic [15:0] wd,
                           input int s, input int t, input int h, input int e,
                           input bit ext, input int rdy_at);
    int n_set = 0, n_str = 0, n_hold = 0, n_rec = 0, n_busy = 0, n_done = 0;
    int done_cyc = -1, bad_addr = 0, bad_line = 0, bad_data = 0, exp_str;
    int got_rd = 0, last_in = 0;
    bit seen = 0, hung = 1;
    dev_ready = (rdy_at == -2);
    repeat (4) @(negedge clk);
    pat = pat + 8'h13;
    req_write = wr; req_index = idx; req_wdata = wd; rdy_ext_en = ext;
    timing = {e[7:0], h[7:0], t[7:0], s[7:0]};
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      if (rsp_valid) begin n_done++; done_cyc = cyc; got_rd = rsp_rdata; end
      if (busy) n_busy++;
      if (!dev_cs_n) begin
        if (dev_addr != idx) bad_addr++;
        if (wr ? !(dev_data_oe && dev_data_out == wd) : dev_data_oe) bad_data++;
        if (!dev_rd_n || !dev_wr_n) begin
          n_str++; seen = 1; last_in = dev_data_in;
          if (wr ? dev_wr_n : dev_rd_n) bad_line++;
        end else if (!seen) n_set++;
        else n_hold++;
      end else if (busy) n_rec++;
      if (!busy) begin hung = 0; break; end
      if (cyc == rdy_at) dev_ready = 1'b1;
      @(negedge clk);
    end
    exp_str = t + 1;
    if (ext && rdy_at >= 0 && rdy_at + 3 - s > exp_str) exp_str = rdy_at + 3 - s;
    check("R9 transfer completes", int'(hung), 0);
    check("R2 setup clocks", n_set, s);
    check("R2 address held", bad_addr, 0);
    check(ext ? "R10 strobe clocks" : "R3 R11 strobe clocks", n_str, exp_str);
    check("R3 strobe line", bad_line, 0);
    check("R4 hold clocks", n_hold, h);
    check("R4 data drive", bad_data, 0);
    check("R7 recovery clocks", n_rec, e);
    check("R7 busy clocks", n_busy, s + exp_str + h + e);
    check("R6 done count", n_done, 1);
    check("R6 done position", done_cyc, s + exp_str + h);
    check("R5 read data", got_rd, wr ? 0 : last_in);
  endtask

  initial begin
    int bcnt, badr;
    repeat (3) @(negedge clk);
    // R1 reset state, during and after reset
    check("R1 cs_n", int'(dev_cs_n), 1);
    check("R1 strobes", int'(dev_rd_n & dev_wr_n), 1);
    check("R1 oe/busy/rsp", int'(dev_data_oe | busy | rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(req_ready), 1);
    check("R1 busy after reset", int'(busy), 0);

    // near-exhaustive sweep of small phase counts (R2-R7, R9)
    for (int s = 0; s < 3; s++)
      for (int t = 0; t < 3; t++)
        for (int h = 0; h < 3; h++)
          for (int e = 0; e < 3; e++)
            for (int w = 0; w < 2; w++)
              run_cycle(w[0], 4'(s * 5 + t + h + e), 16'hC3A5 ^ 16'(s * 4096 + t * 256 + h * 16 + e),
                        s, t, h, e, 1'b0, -1);

    // R9 extreme packed words, slowest and fastest
    run_cycle(1'b0, 4'd3,  16'h0000, 4, 28, 2, 24, 1'b0, -1);
    run_cycle(1'b1, 4'd12, 16'hFFFF, 4, 28, 2, 24, 1'b0, -1);
    run_cycle(1'b0, 4'd15, 16'h0000, 0, 6, 0, 2, 1'b0, -1);
    run_cycle(1'b1, 4'd0,  16'h8001, 0, 6, 0, 2, 1'b0, -1);

    // R10 ready stretch, R11 ready ignored
    for (int r = 0; r < 10; r++) begin
      run_cycle(r[0], 4'(r), 16'(r * 777), 1, 2, 1, 1, 1'b1, r);
    end
    run_cycle(1'b0, 4'd7, 16'h0, 2, 1, 1, 1, 1'b1, -2);
    run_cycle(1'b1, 4'd8, 16'h1234, 2, 1, 1, 1, 1'b0, -1);
    run_cycle(1'b0, 4'd9, 16'h0, 0, 0, 0, 0, 1'b0, -1);

    // read followed by write to the same register (read-modify-write)
    run_cycle(1'b0, 4'd6, 16'h0, 1, 3, 1, 2, 1'b0, -1);
    run_cycle(1'b1, 4'd6, 16'hBEEF, 1, 3, 1, 2, 1'b0, -1);

    // R8 request while busy is not performed
    repeat (4) @(negedge clk);
    req_write = 1'b0; req_index = 4'd5; rdy_ext_en = 1'b0;
    timing = {8'd2, 8'd1, 8'd8, 8'd1};
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    bcnt = 0; badr = 0;
    for (int i = 0; i < 40; i++) begin
      if (busy) bcnt++;
      if (!dev_cs_n && dev_addr != 4'd5) badr++;
      if (i == 3) begin
        check("R8 ready low while busy", int'(req_ready), 0);
        req_valid = 1'b1; req_index = 4'd9;
      end
      if (i == 4) req_valid = 1'b0;
      @(negedge clk);
    end
    check("R8 busy clocks single transfer", bcnt, 13);
    check("R8 address of ignored request", badr, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule